// File: doc/BRIEF.md
# Serial EEPROM Target

This block acts as the target side of a two-wire serial bus and presents a small byte-wide memory, 512 bytes by default. It samples the clock and data lines with the system clock and finds bus start and stop events in the sampled levels. It pulls the data line low through an open-drain enable. The memory can hold a nonvolatile image in a larger design, or a configuration table. A bus master reaches it with the usual serial-memory transactions.

A single address pointer lives across transactions. A write transaction loads the pointer from a block-select bit in the control byte and a following address byte. Any data bytes that follow are stored one after another. A read that comes after a repeated start returns the byte at that address, which makes a random read. A read with no address phase continues from wherever the pointer was left. The master keeps a read going by acknowledging each byte. It ends the read with a not-acknowledge followed by a stop.

Top module: `serial_mem_target`

## Requirements
- R1: After a synchronous reset, `sda_oe` is 0, the pointer is 0x000 and the target waits for a start.
- R2: A start is a falling SDA while SCL is high. A stop is a rising SDA while SCL is high. The target changes `sda_oe` only while SCL is low. A start seen at any point, including partway through a byte, begins a new control byte.
- R3: Bits go MSB first. The control byte is `1010 x x B R`, where B is the block bit and R is read (1) or write (0). A control byte whose top nibble is 1010 is acknowledged by pulling SDA low on the ninth clock. Any other control byte gets no acknowledge, and the target ignores the bus until the next start.
- R4: In a write, the byte after the control byte is acknowledged and loads the pointer. B supplies pointer bit 8 and the byte supplies bits 7:0.
- R5: Each further byte in a write is acknowledged and stored at the pointer, and the pointer then advances by one.
- R6: A repeated start after the address acknowledge, followed by a read control byte, returns the byte at the loaded address.
- R7: A read with no address phase returns the byte at the last accessed address plus one. In a read, B is ignored.
- R8: After a master acknowledge the target sends the next byte. After a master not-acknowledge it releases SDA, and it still has SDA released after a stop.
- R9: The pointer wraps from 0x1FF to 0x000 in both reads and writes.
- R10: A stop or start that comes before the ninth clock of a byte leaves the pointer unchanged, and the memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
The bench writes all 512 locations in one transaction and reads them back in one sequential read. A pointer that does not advance, or that drops bit 8, shows up as a mismatch at some address. A random read that starts at 0x1FE and crosses the top of the array catches a pointer that does not wrap, which would return stale or out-of-range data. A control byte with the wrong device code, and a data byte cut off by a stop or a repeated start, are each followed by a current-address read. An acknowledge on a foreign code, or a write or pointer step from a partial byte, changes the byte that read returns.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } seeprom_state_e;
endpackage

// File: rtl/seeprom_line_sync.sv
module seeprom_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sr;
  logic [LAST:0] sda_sr;
  logic          scl_prev;
  logic          sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_in;
          sda_sr <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[LAST-1:0], scl_in};
          sda_sr <= {sda_sr[LAST-1:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_sr[LAST];
      sda_prev <= sda_sr[LAST];
    end
  end

  assign scl_lvl    = scl_sr[LAST];
  assign sda_lvl    = sda_sr[LAST];
  assign scl_rise   = scl_lvl & ~scl_prev;
  assign scl_fall   = ~scl_lvl & scl_prev;
  assign start_seen = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_seen  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !stop_seen);
endmodule

// File: rtl/seeprom_store.sv
module seeprom_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

  assert_wr_addr_known_R5: assert property (@(posedge clk)
    we |-> !$isunknown(waddr));
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter int         ADDR_W      = 9,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  import seeprom_pkg::*;

  localparam int               HI_W    = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] PTR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] PTR_TOP = {ADDR_W{1'b1}};

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;

  seeprom_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_lvl    (scl_lvl),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  seeprom_state_e    st;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sr;
  logic [7:0]        tx_sr;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   blk;
  logic              rd_mode;
  logic              more;
  logic [7:0]        rd_q;
  logic              mem_we;
  logic              byte_end;

  assign byte_end = scl_fall && (bit_cnt == 4'd8);
  assign mem_we   = (st == ST_WR) && byte_end && !start_seen && !stop_seen;

  seeprom_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (rx_sr),
    .raddr (ptr),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      ptr     <= '0;
      blk     <= '0;
      rd_mode <= 1'b0;
      more    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_seen) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (start_seen) begin
      st      <= ST_CTRL;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (st)
        ST_CTRL, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            bit_cnt <= '0;
            if (st == ST_CTRL) begin
              if (rx_sr[7:4] == DEV_CODE) begin
                rd_mode <= rx_sr[0];
                blk     <= rx_sr[HI_W:1];
                st      <= ST_CTRL_ACK;
                sda_oe  <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_ADDR) begin
              ptr    <= {blk, rx_sr};
              st     <= ST_ADDR_ACK;
              sda_oe <= 1'b1;
            end else begin
              ptr    <= ptr + PTR_ONE;
              st     <= ST_WR_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              st     <= ST_RD;
              tx_sr  <= rd_q;
              sda_oe <= ~rd_q[7];
            end else begin
              st     <= ST_ADDR;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            st     <= ST_WR;
            sda_oe <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            bit_cnt <= '0;
            ptr     <= ptr + PTR_ONE;
            st      <= ST_RD_ACK;
            sda_oe  <= 1'b0;
          end else if (scl_fall) begin
            tx_sr  <= {tx_sr[6:0], 1'b0};
            sda_oe <= ~tx_sr[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            more <= ~sda_lvl;
          end else if (scl_fall) begin
            if (more) begin
              st     <= ST_RD;
              tx_sr  <= rd_q;
              sda_oe <= ~rd_q[7];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

  assert_sda_hold_R2: assert property (@(posedge clk) disable iff (rst)
    scl_lvl |=> $stable(sda_oe));

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_oe);

  assert_bad_code_nack_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CTRL && byte_end && rx_sr[7:4] != DEV_CODE && !start_seen && !stop_seen)
      |=> (st == ST_IDLE && !sda_oe));

  assert_abort_ptr_R10: assert property (@(posedge clk) disable iff (rst)
    (start_seen || stop_seen) |=> $stable(ptr));

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && byte_end && ptr == PTR_TOP && !start_seen && !stop_seen)
      |=> (ptr == '0));

  assert_rst_idle_R1: assert property (@(posedge clk)
    rst |=> (!sda_oe && st == ST_IDLE));
endmodule

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic line;

  assign line = sda_m & ~sda_oe;

  serial_mem_target u_dut (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_m),
    .sda_in (line),
    .sda_oe (sda_oe)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [512];

  function automatic logic [7:0] pat(input int a);
    pat = 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(3); sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(3); sda_m = 1'b0; tick(3); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(3); sda_m = 1'b0; tick(3); scl_m = 1'b1; tick(3); sda_m = 1'b1; tick(3);
  endtask

  task automatic bit_out(input logic b);
    tick(3); sda_m = b; tick(3); scl_m = 1'b1; tick(6); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(3); sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(3); b = line; tick(3); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~mack);
  endtask

  task automatic cur_read(input string tag, input int expv);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ak);
    chk(ak, tag, 0, 1);
    recv_byte(1'b0, d);
    chk(d == 8'(expv), tag, d, expv);
    bus_stop();
  endtask

  task automatic rand_read(input int addr, input string tag, input int expv);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({6'b101000, 1'(addr >> 8), 1'b0}, ak);
    send_byte(8'(addr), ak);
    bus_start();
    send_byte({6'b101000, 1'b0, 1'b1}, ak);
    chk(ak, tag, 0, 1);
    recv_byte(1'b0, d);
    chk(d == 8'(expv), tag, d, expv);
    bus_stop();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    logic ak;
    logic [7:0] d;
    int errs;
    for (int a = 0; a < 512; a++) exp_mem[a] = pat(a);

    tick(6);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    tick(6);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    // R4 R5: fill the whole array in one write from address 0
    bus_start();
    send_byte(8'hA0, ak);
    chk(ak, "R3 ctrl ack", 0, 1);
    send_byte(8'h00, ak);
    chk(ak, "R4 addr ack", 0, 1);
    errs = 0;
    for (int a = 0; a < 512; a++) begin
      send_byte(pat(a), ak);
      if (!ak) errs++;
    end
    chk(errs == 0, "R5 data acks", errs, 0);
    bus_stop();

    // R6 R8 R9: random read at 0x1FE with B=1, chained across the top
    bus_start();
    send_byte(8'hA2, ak);
    send_byte(8'hFE, ak);
    chk(ak, "R4 addr ack B=1", 0, 1);
    bus_start();
    send_byte(8'hA3, ak);
    chk(ak, "R6 read ctrl ack", 0, 1);
    recv_byte(1'b1, d);
    chk(d == exp_mem[9'h1FE], "R6 random read", d, exp_mem[9'h1FE]);
    recv_byte(1'b1, d);
    chk(d == exp_mem[9'h1FF], "R8 chained read", d, exp_mem[9'h1FF]);
    recv_byte(1'b0, d);
    chk(d == exp_mem[0], "R9 wrap read", d, exp_mem[0]);
    bus_stop();
    tick(4);
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

    cur_read("R7 current read", exp_mem[1]);

    // R8: sequential read of the whole array
    bus_start();
    send_byte(8'hA0, ak);
    send_byte(8'h00, ak);
    bus_start();
    send_byte(8'hA1, ak);
    errs = 0;
    for (int a = 0; a < 512; a++) begin
      recv_byte(a != 511, d);
      if (d != exp_mem[a]) begin
        errs++;
        if (errs < 4) chk(1'b0, "R8 sequential byte", d, exp_mem[a]);
      end
    end
    chk(errs == 0, "R8 full sequential read", errs, 0);
    bus_stop();
    cur_read("R9 pointer wrapped after 512", exp_mem[0]);

    // R3: foreign device code is not acknowledged and the bus is ignored
    bus_start();
    send_byte(8'h52, ak);
    chk(!ak, "R3 foreign code nack", ak, 0);
    send_byte(8'h00, ak);
    chk(!ak, "R3 ignored after nack", ak, 0);
    send_byte(8'h77, ak);
    chk(!ak, "R3 still ignored", ak, 0);
    bus_stop();
    cur_read("R3 pointer untouched", exp_mem[1]);

    // R5 R7: single byte write at 0x123
    bus_start();
    send_byte(8'hA2, ak);
    send_byte(8'h23, ak);
    send_byte(8'hC3, ak);
    chk(ak, "R5 single write ack", 0, 1);
    bus_stop();
    exp_mem[9'h123] = 8'hC3;
    cur_read("R7 read after write", exp_mem[9'h124]);
    rand_read(9'h123, "R5 written byte", 8'hC3);

    // R9: write that crosses the top of the array
    bus_start();
    send_byte(8'hA2, ak);
    send_byte(8'hFF, ak);
    send_byte(8'h3C, ak);
    send_byte(8'h96, ak);
    bus_stop();
    exp_mem[9'h1FF] = 8'h3C;
    exp_mem[0] = 8'h96;
    rand_read(0, "R9 write wrap", 8'h96);
    rand_read(9'h1FF, "R9 write top", 8'h3C);

    // R10: stop in the middle of a data byte
    bus_start();
    send_byte(8'hA0, ak);
    send_byte(8'h40, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    cur_read("R10 stop mid byte", exp_mem[9'h40]);

    // R2 R10: repeated start in the middle of a control byte
    bus_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_start();
    send_byte(8'hA1, ak);
    chk(ak, "R2 restart mid byte ack", 0, 1);
    recv_byte(1'b0, d);
    chk(d == exp_mem[9'h41], "R10 restart mid byte", d, exp_mem[9'h41]);
    bus_stop();

    summary();
  end
endmodule